// File: doc/BRIEF.md
# I2C Slave with SCL Deglitch Filter

This block is an I2C slave that runs from a fast system clock and samples the bus lines as ordinary inputs. The SCL sample passes through a digital filter with a selectable length. The filtered clock and a registered copy of SDA are used to find START and STOP conditions, to shift in the 7-bit address, the direction bit and the write data, and to shift out read data. All shifting is MSB first. The slave pulls SDA low through a single output enable. The bus resolution (`sda_in` is the wired-AND of all drivers) is left to the surrounding pad logic.

A host sets the slave address, the filter length, the acknowledge level for received bytes, the next byte to transmit and a bus time-out limit. It reads back the received byte and a set of status flags: address matched, bus busy, byte complete, transfer direction and time-out. A one-cycle interrupt pulse marks each address match and each completed byte. A single clear input removes the sticky byte-complete and time-out flags.

Top module: `i2c_dbslave`

## Requirements
- R1: `deb_sel` sets the SCL filter length: 00 gives 1 system clock, 01 gives 2 and 10 or 11 give 4. The filtered SCL takes a new level only after raw `scl_in` has held that level for that many consecutive clocks, so shorter pulses on a steady SCL have no effect on the received bits.
- R2: A START (SDA falling while filtered SCL is high) sets `bus_busy`. A STOP (SDA rising while filtered SCL is high) clears it. `sda_oe` is 0 whenever `bus_busy` is 0.
- R3: After a START the first 8 bits are 7 address bits, MSB first, and then a direction bit. If the address equals `own_addr`, `addr_match` is set, `irq` pulses once and the slave drives SDA low (`sda_oe`=1) in the 9th clock slot.
- R4: The direction bit is latched into `rd_dir`. A value of 1 means the master reads (slave transmits) and 0 means the master writes.
- R5: In a write, each byte is shifted in MSB first and appears on `rx_data` after its 8th bit. At the same time `xfer_done` is set and `irq` pulses once.
- R6: In the acknowledge slot after a received data byte, the slave drives the level given by `tx_ack`: 0 pulls SDA low (ACK) and 1 leaves it released (NACK).
- R7: In a read, `tx_data` is loaded at the address acknowledge and again at each master ACK, and is driven MSB first. `xfer_done` and `irq` follow each byte. A master NACK makes the slave release SDA until the next START or STOP.
- R8: On an address mismatch the slave never drives SDA, raises no flag or `irq`, and leaves `rx_data` unchanged until the next START or STOP.
- R9: With `to_en`=1 and `bus_busy`=1, if filtered SCL does not change for `to_limit` clocks, `timeout` is set, `bus_busy` and `addr_match` clear and SDA is released. With `to_en`=0 the time-out never fires.
- R10: `flag_clr` clears `xfer_done` and `timeout` on the next clock. `irq` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL sample |
| sda_in | input | 1 | Resolved SDA sample |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Slave address |
| deb_sel | input | 2 | SCL filter length select |
| tx_ack | input | 1 | Acknowledge level for received bytes (0 = ACK) |
| tx_data | input | 8 | Next byte to transmit |
| to_en | input | 1 | Bus time-out enable |
| to_limit | input | TO_W | Time-out length in system clocks |
| flag_clr | input | 1 | Clears `xfer_done` and `timeout` |
| rx_data | output | 8 | Last received byte |
| addr_match | output | 1 | Address matched in the current transfer |
| bus_busy | output | 1 | Bus between START and STOP |
| xfer_done | output | 1 | Sticky byte-complete flag |
| rd_dir | output | 1 | Latched direction bit (1 = slave transmits) |
| timeout | output | 1 | Sticky bus time-out flag |
| irq | output | 1 | One-cycle pulse on address match or byte complete |

## Verification
The assertions check several rules on every cycle. SDA is never pulled while the bus is idle or while the address has not matched. The interrupt is never longer than one cycle. The byte-complete flag only rises together with an interrupt. A time-out always leaves the bus idle and only happens when it is enabled. The bench scenarios are needed for the properties that depend on the data. These are the bit order of received and transmitted bytes, the acknowledge levels seen on the bus, the rejection of SCL glitches at each filter setting, the silence after a mismatch or a master NACK, and the point at which a stalled clock trips the time-out.

// File: rtl/i2c_dbslave.sv
module i2c_dbslave #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  input  logic [6:0]      own_addr,
  input  logic [1:0]      deb_sel,
  input  logic            tx_ack,
  input  logic [7:0]      tx_data,
  input  logic            to_en,
  input  logic [TO_W-1:0] to_limit,
  input  logic            flag_clr,
  output logic [7:0]      rx_data,
  output logic            addr_match,
  output logic            bus_busy,
  output logic            xfer_done,
  output logic            rd_dir,
  output logic            timeout,
  output logic            irq
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_RX, S_TX} st_t;

  logic [1:0]      dcnt;
  logic [1:0]      dlast;
  logic            scl_f, scl_p, sda_q, sda_p;
  st_t             state;
  logic [3:0]      bitcnt;
  logic [7:0]      sh;
  logic [TO_W-1:0] to_cnt;

  assign dlast = (deb_sel == 2'b00) ? 2'd0 : (deb_sel == 2'b01) ? 2'd1 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_f <= 1'b1;
      dcnt  <= '0;
    end else if (scl_in != scl_f) begin
      if (dcnt == dlast) begin
        scl_f <= scl_in;
        dcnt  <= '0;
      end else begin
        dcnt <= dcnt + 2'd1;
      end
    end else begin
      dcnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_q <= sda_in;
      sda_p <= sda_q;
    end
  end

  wire rise    = scl_f & ~scl_p;
  wire fall    = ~scl_f & scl_p;
  wire start_c = scl_f & scl_p & sda_p & ~sda_q;
  wire stop_c  = scl_f & scl_p & ~sda_p & sda_q;
  wire last_b  = (bitcnt == 4'd7);
  wire ack_b   = (bitcnt == 4'd8);
  wire to_hit  = to_en & bus_busy & ~(rise | fall) & (to_cnt == to_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bitcnt     <= '0;
      sh         <= '0;
      rx_data    <= '0;
      sda_oe     <= 1'b0;
      addr_match <= 1'b0;
      bus_busy   <= 1'b0;
      xfer_done  <= 1'b0;
      rd_dir     <= 1'b0;
      timeout    <= 1'b0;
      irq        <= 1'b0;
      to_cnt     <= '0;
    end else begin
      irq <= 1'b0;
      if (flag_clr) begin
        xfer_done <= 1'b0;
        timeout   <= 1'b0;
      end

      if (!bus_busy || !to_en || rise || fall) to_cnt <= '0;
      else                                   to_cnt <= to_cnt + 1'b1;

      if (rise) begin
        case (state)
          S_ADDR: begin
            if (!ack_b) begin
              sh     <= {sh[6:0], sda_q};
              bitcnt <= bitcnt + 4'd1;
              if (last_b) begin
                if (sh[6:0] == own_addr) begin
                  addr_match <= 1'b1;
                  rd_dir     <= sda_q;
                  irq        <= 1'b1;
                end else begin
                  state <= S_IDLE;
                end
              end
            end else begin
              bitcnt <= '0;
              if (rd_dir) begin
                state <= S_TX;
                sh    <= tx_data;
              end else begin
                state <= S_RX;
              end
            end
          end
          S_RX: begin
            if (!ack_b) begin
              sh     <= {sh[6:0], sda_q};
              bitcnt <= bitcnt + 4'd1;
              if (last_b) begin
                rx_data   <= {sh[6:0], sda_q};
                xfer_done <= 1'b1;
                irq       <= 1'b1;
              end
            end else begin
              bitcnt <= '0;
            end
          end
          S_TX: begin
            if (!ack_b) begin
              bitcnt <= bitcnt + 4'd1;
              if (last_b) begin
                xfer_done <= 1'b1;
                irq       <= 1'b1;
              end
            end else begin
              bitcnt <= '0;
              if (sda_q) state <= S_IDLE;
              else       sh    <= tx_data;
            end
          end
          default: ;
        endcase
      end

      if (fall) begin
        case (state)
          S_ADDR:  sda_oe <= ack_b & addr_match;
          S_RX:    sda_oe <= ack_b & ~tx_ack;
          S_TX:    sda_oe <= ~ack_b & ~sh[3'd7 - bitcnt[2:0]];
          default: sda_oe <= 1'b0;
        endcase
      end

      if (start_c) begin
        state      <= S_ADDR;
        bitcnt     <= '0;
        bus_busy   <= 1'b1;
        addr_match <= 1'b0;
        sda_oe     <= 1'b0;
        to_cnt     <= '0;
      end else if (stop_c) begin
        state      <= S_IDLE;
        bus_busy   <= 1'b0;
        addr_match <= 1'b0;
        sda_oe     <= 1'b0;
      end

      if (to_hit) begin
        timeout    <= 1'b1;
        state      <= S_IDLE;
        bus_busy   <= 1'b0;
        addr_match <= 1'b0;
        sda_oe     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_dbslave_chk.sv
module i2c_dbslave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic addr_match,
  input logic bus_busy,
  input logic xfer_done,
  input logic timeout,
  input logic to_en,
  input logic irq
);

  assert_oe_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> !sda_oe);

  assert_oe_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_match |-> !sda_oe);

  assert_done_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> irq);

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> (!bus_busy && !addr_match && !sda_oe));

  assert_to_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(to_en));

endmodule

bind i2c_dbslave i2c_dbslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .addr_match(addr_match),
  .bus_busy(bus_busy), .xfer_done(xfer_done), .timeout(timeout),
  .to_en(to_en), .irq(irq)
);

// File: tb/tb_i2c_dbslave.sv
`timescale 1ns/1ps
module tb_i2c_dbslave;
  localparam int TO_W = 16;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_in;
  logic [6:0] own_addr = '0;
  logic [1:0] deb_sel = '0;
  logic tx_ack = 1'b0;
  logic [7:0] tx_data = '0;
  logic to_en = 1'b0;
  logic [TO_W-1:0] to_limit = '1;
  logic flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic addr_match, bus_busy, xfer_done, rd_dir, timeout, irq;

  int nchecks = 0, nerr = 0, irq_cnt = 0, glen = 0;

  always #2.5 clk = ~clk;
  assign sda_in = sda_m & ~sda_oe;
  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  i2c_dbslave #(.TO_W(TO_W)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_in), .sda_oe(sda_oe),
    .own_addr(own_addr), .deb_sel(deb_sel), .tx_ack(tx_ack), .tx_data(tx_data),
    .to_en(to_en), .to_limit(to_limit), .flag_clr(flag_clr), .rx_data(rx_data),
    .addr_match(addr_match), .bus_busy(bus_busy), .xfer_done(xfer_done),
    .rd_dir(rd_dir), .timeout(timeout), .irq(irq));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;
    if (glen > 0) begin
      w(2); scl_m = 1'b1; w(glen); scl_m = 1'b0;
    end
    w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_in; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack, input logic [7:0] nxt);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    tx_data = nxt;
    put_bit(mack);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; w(1); flag_clr = 1'b0; w(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] got, b0, b1, rx_before;
    logic [6:0] a;
    int base;
    w(4); rst_n = 1'b1; w(2);
    check("R2", "reset busy", bus_busy, 0);
    check("R2", "reset oe", sda_oe, 0);
    check("R3", "reset match", addr_match, 0);
    check("R10", "reset done", xfer_done, 0);
    check("R9", "reset timeout", timeout, 0);

    for (int d = 0; d < 4; d++) begin
      deb_sel = d[1:0];
      glen = (d == 0) ? 0 : (d == 1) ? 1 : 3;
      for (int ai = 0; ai < 4; ai++) begin
        a = (ai == 0) ? 7'h00 : (ai == 1) ? 7'h2A : (ai == 2) ? 7'h55 : 7'h7F;
        own_addr = a;
        b0 = 8'((ai * 37 + d * 11 + 5) & 8'hFF);
        b1 = ~b0;
        // write transfer
        tx_ack = 1'b0;
        base = irq_cnt;
        bus_start();
        check("R2", "busy after start", bus_busy, 1);
        send_byte({a, 1'b0}, ack);
        check("R3", "address ack", ack, 0);
        check("R3", "addr_match", addr_match, 1);
        check("R3", "irq on match", irq_cnt, base + 1);
        check("R4", "rd_dir write", rd_dir, 0);
        send_byte(b0, ack);
        check("R6", "data ack", ack, 0);
        check("R5 R1", "rx_data", rx_data, b0);
        check("R5", "xfer_done", xfer_done, 1);
        check("R5", "irq on byte", irq_cnt, base + 2);
        pulse_clr();
        check("R10", "done cleared", xfer_done, 0);
        tx_ack = 1'b1;
        send_byte(b1, ack);
        check("R6", "data nack", ack, 1);
        check("R5 R1", "rx_data 2", rx_data, b1);
        bus_stop();
        check("R2", "busy after stop", bus_busy, 0);
        check("R2", "oe after stop", sda_oe, 0);
        // read transfer
        tx_data = b1;
        pulse_clr();
        bus_start();
        send_byte({a, 1'b1}, ack);
        check("R3", "read address ack", ack, 0);
        check("R4", "rd_dir read", rd_dir, 1);
        recv_byte(got, 1'b0, b0);
        check("R7", "read byte 1", got, b1);
        check("R7", "read done", xfer_done, 1);
        recv_byte(got, 1'b1, 8'h00);
        check("R7", "read byte 2", got, b0);
        w(3 * Q);
        check("R7", "released after nack", sda_oe, 0);
        bus_stop();
        // mismatched address
        pulse_clr();
        rx_before = rx_data;
        base = irq_cnt;
        bus_start();
        send_byte({a ^ 7'h01, 1'b0}, ack);
        check("R8", "no address ack", ack, 1);
        check("R8", "no match", addr_match, 0);
        send_byte(8'hC3, ack);
        check("R8", "no data ack", ack, 1);
        check("R8", "rx unchanged", rx_data, rx_before);
        check("R8", "no done", xfer_done, 0);
        check("R8", "no irq", irq_cnt, base);
        bus_stop();
      end
    end

    // bus time-out
    deb_sel = 2'b00; glen = 0; tx_ack = 1'b0;
    to_en = 1'b1; to_limit = 16'd60;
    bus_start();
    send_byte({own_addr, 1'b0}, ack);
    check("R9", "no early timeout", timeout, 0);
    check("R9", "busy before stall", bus_busy, 1);
    w(100);
    check("R9", "timeout set", timeout, 1);
    check("R9", "busy cleared", bus_busy, 0);
    check("R9", "match cleared", addr_match, 0);
    check("R9", "oe released", sda_oe, 0);
    pulse_clr();
    check("R10", "timeout cleared", timeout, 0);
    scl_m = 1'b1; w(Q);
    to_en = 1'b0;
    bus_start();
    w(300);
    check("R9", "disabled no timeout", timeout, 0);
    check("R9", "disabled still busy", bus_busy, 1);
    bus_stop();
    check("R2", "final idle", bus_busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule